// File: doc/BRIEF.md
# Memory Range Decoder Bank with Timed Commit

This block is a register bank reached through a simple 32-bit read/write port. It holds a parameterised number of memory range decoders, and each decoder describes one window of host-managed memory. Software programs a decoder's 64-bit base, 64-bit size, 64-bit target list and a control word. The control word carries the interleave granularity code, the interleave ways code, the target type, a lock bit and a commit request.

A decoder's range does not take effect as soon as it is written. Software raises the commit request, and a programmable number of clock cycles later the decoder reports itself committed. Only a committed decoder claims addresses. The bank drives every decoder's effective configuration to a downstream routing block: a live flag, a lock flag, base, size, targets, granularity, ways and type. A committed decoder whose lock bit is set is frozen against any further register write until reset. The commit delay is counted in clock cycles and must be chosen to stay below the 10 ms commit timeout at the clock rate in use.

Top module: `mdec_bank`

## Requirements
- R1: A read of offset 0x0 returns the capability word. It holds NUM_DEC in bits 3:0, TGT_CNT in bits 7:4, the low-interleave support flag (address bits 11:8) in bit 8, the high-interleave support flag (address bits 14:12) in bit 9, and zero elsewhere. NUM_DEC must be 1 to 15, because a count code of zero is invalid. Writes to this word have no effect.
- R2: Offset 0x4 holds the global enable in bit 1 and reads zero in every other bit. A decoder's dec_live output is high only while that decoder is committed and the global enable is set.
- R3: Decoder i occupies offsets 0x10+0x20·i through 0x28+0x20·i, in this order: base low 0x10, base high 0x14, size low 0x18, size high 0x1C, control 0x20, target low 0x24, target high 0x28. A read strobe presents the selected word on reg_rdata at the next clock edge, and reg_rdata holds it until the next read.
- R4: The control word layout is: granularity code in bits 3:0, ways code in bits 7:4, lock in bit 8, commit request in bit 9, read-only committed status in bit 10, and target type in bit 12 (1 = memory expander, 0 = accelerator). All other bits read zero, and writes to bit 10 are ignored.
- R5: A control write with bit 9 set, to a decoder that is neither committed nor waiting, sets committed exactly COMMIT_DLY clock edges after the write edge. A repeated request while waiting does not restart the wait.
- R6: While a decoder is not committed, its dec_size output is zero and dec_live is low. Register reads still return the programmed size.
- R7: A control write with bit 9 clear, to an unlocked decoder, clears committed at that write's edge and cancels any wait in progress.
- R8: A decoder that is committed and has its lock bit set drives dec_lock high. From then until reset, writes to its base, size, control and target registers are ignored.
- R9: Reads of any offset that maps to no register return zero: offsets 0x8 to 0xC, the unused slot at 0x2C+0x20·i, and decoder indices at or above NUM_DEC. Writes to those offsets change nothing.
- R10: dec_base, dec_tgt, dec_gran, dec_ways and dec_expander follow each decoder's programmed registers. Decoder i uses slice [64·i +: 64] or [4·i +: 4], or bit i.
- R11: After reset every register, status and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid from the edge after reg_rd |
| dec_live | output | NUM_DEC | Decoder committed and globally enabled |
| dec_lock | output | NUM_DEC | Decoder committed and locked |
| dec_base | output | 64·NUM_DEC | Programmed base per decoder |
| dec_size | output | 64·NUM_DEC | Effective size per decoder, zero when not committed |
| dec_tgt | output | 64·NUM_DEC | Target list per decoder |
| dec_gran | output | 4·NUM_DEC | Granularity code per decoder |
| dec_ways | output | 4·NUM_DEC | Ways code per decoder |
| dec_expander | output | NUM_DEC | Target type per decoder, 1 = memory expander |

## Verification
On every cycle, the assertions check that a lock, once reported, persists and freezes that decoder's base and target outputs. They also check that a clearing control write drops dec_live at the next edge, that a capability read returns the parameter-derived word, and that reads beyond the implemented decoders return zero. The exact commit latency, the cancellation of a pending commit, the masking of control bits, and the gating by the global enable depend on sequences of register traffic. Only the bench's scenarios can show these, with its cycle-by-cycle model compared against every output.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int REG_W = 32;
  localparam int DEC_BASE_OFF = 16;
  localparam int DEC_STRIDE = 32;
  localparam int GCTL_OFF = 4;

  localparam logic [2:0] SUB_BASE_LO = 3'd0;
  localparam logic [2:0] SUB_BASE_HI = 3'd1;
  localparam logic [2:0] SUB_SIZE_LO = 3'd2;
  localparam logic [2:0] SUB_SIZE_HI = 3'd3;
  localparam logic [2:0] SUB_CTRL    = 3'd4;
  localparam logic [2:0] SUB_TGT_LO  = 3'd5;
  localparam logic [2:0] SUB_TGT_HI  = 3'd6;

  localparam int BIT_LOCK = 8;
  localparam int BIT_CREQ = 9;
  localparam int BIT_CMT  = 10;
  localparam int BIT_TYPE = 12;

  typedef struct packed {
    logic       expander;
    logic       lock;
    logic       creq;
    logic [3:0] ways;
    logic [3:0] gran;
  } dec_cfg_t;
endpackage

// File: rtl/mdec_slot.sv
module mdec_slot
  import mdec_pkg::*;
#(
  parameter int COMMIT_DLY = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [2:0]  sub,
  input  logic [31:0] wdata,
  output logic [31:0] rword,
  output logic        committed,
  output logic        locked,
  output logic [63:0] base,
  output logic [63:0] size_eff,
  output logic [63:0] tgt,
  output logic [3:0]  gran,
  output logic [3:0]  ways,
  output logic        expander
);
  localparam int CW = (COMMIT_DLY < 2) ? 1 : $clog2(COMMIT_DLY);
  localparam logic [CW-1:0] CNT_LOAD = CW'(COMMIT_DLY - 1);

  logic [63:0] base_q, size_q, tgt_q;
  dec_cfg_t    cfg_q;
  logic        cmt_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic        frozen, wr_ok, ctrl_wr;

  assign frozen  = cfg_q.lock && cmt_q;
  assign wr_ok   = wr && !frozen;
  assign ctrl_wr = wr_ok && (sub == SUB_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      tgt_q  <= '0;
      cfg_q  <= '0;
      cmt_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (sub)
          SUB_BASE_LO: base_q[31:0]  <= wdata;
          SUB_BASE_HI: base_q[63:32] <= wdata;
          SUB_SIZE_LO: size_q[31:0]  <= wdata;
          SUB_SIZE_HI: size_q[63:32] <= wdata;
          SUB_TGT_LO:  tgt_q[31:0]   <= wdata;
          SUB_TGT_HI:  tgt_q[63:32]  <= wdata;
          SUB_CTRL: begin
            cfg_q.gran     <= wdata[3:0];
            cfg_q.ways     <= wdata[7:4];
            cfg_q.lock     <= wdata[BIT_LOCK];
            cfg_q.creq     <= wdata[BIT_CREQ];
            cfg_q.expander <= wdata[BIT_TYPE];
          end
          default: ;
        endcase
      end
      if (ctrl_wr && !wdata[BIT_CREQ]) begin
        cmt_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (ctrl_wr && !cmt_q && !pend_q) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else if (pend_q) begin
        if (cnt_q == '0) begin
          pend_q <= 1'b0;
          cmt_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (sub)
      SUB_BASE_LO: rword = base_q[31:0];
      SUB_BASE_HI: rword = base_q[63:32];
      SUB_SIZE_LO: rword = size_q[31:0];
      SUB_SIZE_HI: rword = size_q[63:32];
      SUB_CTRL:    rword = {19'b0, cfg_q.expander, 1'b0, cmt_q, cfg_q.creq,
                            cfg_q.lock, cfg_q.ways, cfg_q.gran};
      SUB_TGT_LO:  rword = tgt_q[31:0];
      SUB_TGT_HI:  rword = tgt_q[63:32];
      default:     rword = '0;
    endcase
  end

  assign committed = cmt_q;
  assign locked    = frozen;
  assign base      = base_q;
  assign size_eff  = cmt_q ? size_q : 64'd0;
  assign tgt       = tgt_q;
  assign gran      = cfg_q.gran;
  assign ways      = cfg_q.ways;
  assign expander  = cfg_q.expander;
endmodule

// File: rtl/mdec_rdmux.sv
module mdec_rdmux #(
  parameter int NUM_DEC = 2,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          sel_cap,
  input  logic          sel_gctl,
  input  logic          sel_dec,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   cap_word,
  input  logic          gen,
  input  logic [31:0]   words [NUM_DEC],
  output logic [31:0]   rdata
);
  logic [31:0] pick;

  always_comb begin
    pick = '0;
    if (sel_cap) begin
      pick = cap_word;
    end else if (sel_gctl) begin
      pick = {30'b0, gen, 1'b0};
    end else if (sel_dec) begin
      for (int k = 0; k < NUM_DEC; k++) begin
        if (idx == IW'(k)) pick = words[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= pick;
  end
endmodule

// File: rtl/mdec_bank.sv
module mdec_bank
  import mdec_pkg::*;
#(
  parameter int NUM_DEC    = 2,
  parameter int TGT_CNT    = 1,
  parameter bit IL_LOW     = 1'b1,
  parameter bit IL_HIGH    = 1'b0,
  parameter int COMMIT_DLY = 1000,
  parameter int AW         = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_DEC-1:0]   dec_live,
  output logic [NUM_DEC-1:0]   dec_lock,
  output logic [64*NUM_DEC-1:0] dec_base,
  output logic [64*NUM_DEC-1:0] dec_size,
  output logic [64*NUM_DEC-1:0] dec_tgt,
  output logic [4*NUM_DEC-1:0] dec_gran,
  output logic [4*NUM_DEC-1:0] dec_ways,
  output logic [NUM_DEC-1:0]   dec_expander
);
  localparam int IW = AW - 5;
  localparam logic [31:0] CAP_WORD =
    {22'b0, IL_HIGH, IL_LOW, 4'(TGT_CNT), 4'(NUM_DEC)};

  logic [AW-1:0] rel;
  logic [IW-1:0] idx;
  logic [2:0]    sub;
  logic          in_dec, sel_cap, sel_gctl;
  logic          gen_q;
  logic [31:0]   words [NUM_DEC];
  logic [NUM_DEC-1:0] cmt;

  assign rel      = reg_addr - AW'(DEC_BASE_OFF);
  assign in_dec   = reg_addr >= AW'(DEC_BASE_OFF);
  assign idx      = rel[AW-1:5];
  assign sub      = rel[4:2];
  assign sel_cap  = reg_addr == '0;
  assign sel_gctl = reg_addr == AW'(GCTL_OFF);

  always_ff @(posedge clk) begin
    if (rst) gen_q <= 1'b0;
    else if (reg_wr && sel_gctl) gen_q <= reg_wdata[1];
  end

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic slot_wr;
    assign slot_wr = reg_wr && in_dec && (idx == IW'(i));

    mdec_slot #(.COMMIT_DLY(COMMIT_DLY)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr        (slot_wr),
      .sub       (sub),
      .wdata     (reg_wdata),
      .rword     (words[i]),
      .committed (cmt[i]),
      .locked    (dec_lock[i]),
      .base      (dec_base[64*i +: 64]),
      .size_eff  (dec_size[64*i +: 64]),
      .tgt       (dec_tgt[64*i +: 64]),
      .gran      (dec_gran[4*i +: 4]),
      .ways      (dec_ways[4*i +: 4]),
      .expander  (dec_expander[i])
    );

    assign dec_live[i] = cmt[i] && gen_q;
  end

  mdec_rdmux #(.NUM_DEC(NUM_DEC), .IW(IW)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (reg_rd),
    .sel_cap  (sel_cap),
    .sel_gctl (sel_gctl),
    .sel_dec  (in_dec),
    .idx      (idx),
    .cap_word (CAP_WORD),
    .gen      (gen_q),
    .words    (words),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/mdec_bank_chk.sv
module mdec_bank_chk #(
  parameter int NUM_DEC = 2,
  parameter int TGT_CNT = 1,
  parameter bit IL_LOW  = 1'b1,
  parameter bit IL_HIGH = 1'b0,
  parameter int AW      = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [AW-1:0]         reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [31:0]           reg_rdata,
  input logic [NUM_DEC-1:0]    dec_live,
  input logic [NUM_DEC-1:0]    dec_lock,
  input logic [64*NUM_DEC-1:0] dec_base,
  input logic [64*NUM_DEC-1:0] dec_tgt
);
  localparam logic [AW-1:0] END_ADDR = AW'(16 + 32 * NUM_DEC);
  localparam logic [31:0] CAP_EXP =
    {22'b0, IL_HIGH, IL_LOW, 4'(TGT_CNT), 4'(NUM_DEC)};

  AST_CAP_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == '0) |=> (reg_rdata == CAP_EXP)); // R1

  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr >= END_ADDR) |=> (reg_rdata == 32'd0)); // R9

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_chk
    localparam logic [AW-1:0] CTRL_ADDR = AW'(32 + 32 * i);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
      dec_lock[i] |=> dec_lock[i]); // R8

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
      dec_lock[i] |=> ($stable(dec_base[64*i +: 64]) && $stable(dec_tgt[64*i +: 64]))); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == CTRL_ADDR && !reg_wdata[9] && !dec_lock[i]) |=> !dec_live[i]); // R7
  end
endmodule

bind mdec_bank mdec_bank_chk #(
  .NUM_DEC(NUM_DEC), .TGT_CNT(TGT_CNT), .IL_LOW(IL_LOW), .IL_HIGH(IL_HIGH), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_live(dec_live),
  .dec_lock(dec_lock), .dec_base(dec_base), .dec_tgt(dec_tgt)
);

// File: tb/mdec_bank_test.sv
`timescale 1ns/1ps
module mdec_bank_test;
  localparam int CLK_NS = 10;
  localparam int N = 3;
  localparam int TGT = 2;
  localparam int DLY = 5;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] dec_live, dec_lock, dec_expander;
  logic [64*N-1:0] dec_base, dec_size, dec_tgt;
  logic [4*N-1:0] dec_gran, dec_ways;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  mdec_bank #(.NUM_DEC(N), .TGT_CNT(TGT), .IL_LOW(1'b1), .IL_HIGH(1'b1),
              .COMMIT_DLY(DLY), .AW(AW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_live(dec_live),
    .dec_lock(dec_lock), .dec_base(dec_base), .dec_size(dec_size),
    .dec_tgt(dec_tgt), .dec_gran(dec_gran), .dec_ways(dec_ways),
    .dec_expander(dec_expander)
  );

  // behavioural reference model
  logic [63:0] m_base [N];
  logic [63:0] m_size [N];
  logic [63:0] m_tgt  [N];
  logic [3:0]  m_gran [N];
  logic [3:0]  m_ways [N];
  bit m_lock [N];
  bit m_creq [N];
  bit m_type [N];
  bit m_cmt  [N];
  bit m_pend [N];
  int m_cnt  [N];
  bit m_gen;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input int a);
    int d, s;
    if (a == 0) return 32'h0000_0323;
    if (a == 4) return {30'b0, m_gen, 1'b0};
    if (a < 16) return 32'd0;
    d = (a - 16) / 32;
    s = ((a - 16) % 32) / 4;
    if (d >= N) return 32'd0;
    case (s)
      0: return m_base[d][31:0];
      1: return m_base[d][63:32];
      2: return m_size[d][31:0];
      3: return m_size[d][63:32];
      4: return {19'b0, m_type[d], 1'b0, m_cmt[d], m_creq[d], m_lock[d], m_ways[d], m_gran[d]};
      5: return m_tgt[d][31:0];
      6: return m_tgt[d][63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < N; d++) begin
        m_base[d] = 0; m_size[d] = 0; m_tgt[d] = 0; m_gran[d] = 0; m_ways[d] = 0;
        m_lock[d] = 0; m_creq[d] = 0; m_type[d] = 0; m_cmt[d] = 0; m_pend[d] = 0; m_cnt[d] = 0;
      end
      m_gen = 0;
      m_rdata = 0;
    end else begin
      bit cw [N];
      bit nc;
      int a, d, s;
      if (reg_rd) m_rdata = m_read(int'(reg_addr));
      for (int k = 0; k < N; k++) cw[k] = 0;
      nc = reg_wdata[9];
      a = int'(reg_addr);
      if (reg_wr) begin
        if (a == 4) m_gen = reg_wdata[1];
        else if (a >= 16) begin
          d = (a - 16) / 32;
          s = ((a - 16) % 32) / 4;
          if (d < N && !(m_lock[d] && m_cmt[d])) begin
            case (s)
              0: m_base[d][31:0] = reg_wdata;
              1: m_base[d][63:32] = reg_wdata;
              2: m_size[d][31:0] = reg_wdata;
              3: m_size[d][63:32] = reg_wdata;
              4: begin
                m_gran[d] = reg_wdata[3:0]; m_ways[d] = reg_wdata[7:4];
                m_lock[d] = reg_wdata[8]; m_creq[d] = reg_wdata[9];
                m_type[d] = reg_wdata[12]; cw[d] = 1;
              end
              5: m_tgt[d][31:0] = reg_wdata;
              6: m_tgt[d][63:32] = reg_wdata;
              default: ;
            endcase
          end
        end
      end
      for (int k = 0; k < N; k++) begin
        if (cw[k] && !nc) begin
          m_cmt[k] = 0; m_pend[k] = 0;
        end else if (cw[k] && !m_cmt[k] && !m_pend[k]) begin
          m_pend[k] = 1; m_cnt[k] = DLY - 1;
        end else if (m_pend[k]) begin
          if (m_cnt[k] == 0) begin m_pend[k] = 0; m_cmt[k] = 1; end
          else m_cnt[k] = m_cnt[k] - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 rdata", 64'(reg_rdata), 64'(m_rdata));
      for (int d = 0; d < N; d++) begin
        chk("R2/R5 live", 64'(dec_live[d]), 64'(m_cmt[d] && m_gen));
        chk("R8 lock", 64'(dec_lock[d]), 64'(m_cmt[d] && m_lock[d]));
        chk("R6 size", dec_size[64*d +: 64], m_cmt[d] ? m_size[d] : 64'd0);
        chk("R10 base", dec_base[64*d +: 64], m_base[d]);
        chk("R10 tgt", dec_tgt[64*d +: 64], m_tgt[d]);
        chk("R10 gran", 64'(dec_gran[4*d +: 4]), 64'(m_gran[d]));
        chk("R10 ways", 64'(dec_ways[4*d +: 4]), 64'(m_ways[d]));
        chk("R10 type", 64'(dec_expander[d]), 64'(m_type[d]));
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(posedge clk); #1;
    reg_rd = 1'b0;
    @(negedge clk);
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_NS * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 live", 64'(dec_live), 64'd0);
    chk("R11 size", 64'(dec_size[63:0]), 64'd0);
    rdchk(32'h20, 32'd0, "R11 ctrl0");
    // R1 capability and its read-only nature
    rdchk(0, 32'h0000_0323, "R1 cap");
    wr(0, 32'hFFFF_FFFF);
    rdchk(0, 32'h0000_0323, "R1 cap after write");
    // R2 global enable
    wr(4, 32'hFFFF_FFFF);
    rdchk(4, 32'h2, "R2 gctl");
    // decoder 0 programming, R4 masking
    wr(32'h10, 32'h1000_0000);
    wr(32'h14, 32'h0000_0001);
    wr(32'h18, 32'h1000_0000);
    wr(32'h24, 32'h0302_0100);
    wr(32'h20, 32'hFFFF_1E12);
    rdchk(32'h20, 32'h0000_1212, "R4 ctrl before commit");
    @(negedge clk);
    chk("R6 size zero while pending", dec_size[63:0], 64'd0);
    idle(6);
    rdchk(32'h20, 32'h0000_1612, "R5 committed status");
    rdchk(32'h18, 32'h1000_0000, "R3 size low");
    chk("R10 base", dec_base[63:0], 64'h1_1000_0000);
    chk("R6 size live", dec_size[63:0], 64'h1000_0000);
    // R5 exact latency on decoder 1
    wr(32'h40, 32'h200);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5 not early", 64'(dec_live[1]), 64'd0);
    @(negedge clk);
    chk("R5 on time", 64'(dec_live[1]), 64'd1);
    // R7 clear and cancel
    wr(32'h40, 32'h0);
    @(negedge clk);
    chk("R7 cleared", 64'(dec_live[1]), 64'd0);
    wr(32'h40, 32'h200);
    wr(32'h40, 32'h0);
    idle(10);
    @(negedge clk);
    chk("R7 cancelled", 64'(dec_live[1]), 64'd0);
    // R8 lock
    wr(32'h50, 32'h0000_AAAA);
    wr(32'h60, 32'h300);
    idle(8);
    @(negedge clk);
    chk("R8 locked", 64'(dec_lock[2]), 64'd1);
    wr(32'h50, 32'h0000_5555);
    rdchk(32'h50, 32'h0000_AAAA, "R8 base frozen");
    wr(32'h60, 32'h0);
    rdchk(32'h60, 32'h0000_0700, "R8 ctrl frozen");
    // R9 unmapped
    rdchk(32'h08, 32'd0, "R9 gap");
    rdchk(32'h2C, 32'd0, "R9 slot hole");
    wr(32'h70, 32'h1234_5678);
    rdchk(32'h70, 32'd0, "R9 beyond decoders");
    // R2 global disable gates live
    wr(4, 32'h0);
    @(negedge clk);
    chk("R2 disabled", 64'(dec_live), 64'd0);
    wr(4, 32'h2);
    @(negedge clk);
    chk("R2 re-enabled", 64'(dec_live[0]), 64'd1);
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule